// File: doc/BRIEF.md
# Half-Precision Floating-Point Square Root

This block takes the square root of a 16-bit floating-point operand. The word has the sign in bit 15, the exponent in bits 14..10 with a bias of 15, and the stored mantissa in bits 9..0. The exponent path forms the distance of the stored exponent from the bias. A multiplexer picks which of the two is subtracted, and the same compare tells whether the operand is at least 1. The block halves that distance with a one-bit shift and keeps the bit shifted out as an odd-exponent flag.

The significand, with its leading one restored, goes through a controlled right shift so that the root core always sees a pure fraction. When the exponent is odd, the shift is one place shorter, which folds the spare factor of two into the radicand. The core is a restoring bit-serial root that yields one result bit per clock. Its result always lies in [0.5, 1), so the block drops the leading one, truncates to 10 mantissa bits and packs the result with the new biased exponent.

A caller pulses `start_i` with the operand while `busy_o` is low and waits for the one-cycle `done_o` pulse. A +0 operand, or an operand that cannot be rooted, completes on the next edge without using the core. The result and flag stay on the outputs until the next completion.

Top module: `fp16_sqrt`

## Requirements
- R1: An accepted operand with bit 15 set, with exponent field 31, or with exponent field 0 and a non-zero mantissa completes one edge after acceptance with `invalid_o`=1 and `result_o`=16'h7E00.
- R2: An accepted operand 16'h0000 completes one edge after acceptance with `invalid_o`=0 and `result_o`=16'h0000.
- R3: For a normal operand with exponent field e, the result exponent field (bits 14..10) is 15 + floor((e-15)/2).
- R4: For a normal operand with significand S = 1024+mantissa, the result significand Q = 1024+result[9:0] is the truncated root: Q*Q <= S*2^(10+k) < (Q+1)*(Q+1), where k = (e-15) mod 2.
- R5: A normal operand is accepted on the rising edge where `start_i`=1 and `busy_o`=0. `busy_o` is high from the following cycle until `done_o` rises, and `done_o` is first seen high after the 14th rising edge, counting the accepting edge as the first.
- R6: `start_i` has no effect while `busy_o` is high. The result then delivered belongs to the operand that was accepted, and no extra completion follows.
- R7: `done_o` is high for one cycle per completion, and `result_o` and `invalid_o` hold their values until the next completion.
- R8: The exact squares return exact roots: 16'h4400 (4.0) gives 16'h4000, 16'h3400 (0.25) gives 16'h3800, and 16'h3C00 (1.0) gives 16'h3C00.
- R9: An odd unbiased exponent is handled for operands both above and below 1: 16'h4000 (2.0) gives 16'h3DA8, and 16'h3800 (0.5) gives 16'h39A8.
- R10: A valid completion always has `invalid_o`=0 and bit 15 of `result_o` clear. Its exponent field lies between 8 and 22.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Operand valid; taken when busy_o is low |
| op_i | input | 16 | Operand: sign bit 15, exponent 14..10, mantissa 9..0 |
| busy_o | output | 1 | Root in progress; new starts are ignored |
| done_o | output | 1 | One-cycle completion pulse |
| invalid_o | output | 1 | Operand could not be rooted; result is the quiet NaN |
| result_o | output | 16 | Root, held until the next completion |

## Verification
The bound checker watches the special-operand paths (invalid and +0) on every cycle, as well as the busy and done handshake, the single-cycle done pulse, the holding of the result between completions, and the sign and exponent range of valid results. The numerical correctness of the root can only be shown by the bench scenarios. These cover the truncation bound against the squared output significand, the halved exponent for even and odd exponents above and below 1, the exact squares, the 14-edge latency, and the case where a start arrives while busy.

// File: rtl/fp16_sqrt_pkg.sv
package fp16_sqrt_pkg;
  localparam int EXP_W  = 5;
  localparam int MAN_W  = 10;
  localparam int WORD_W = 1 + EXP_W + MAN_W;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int ROOT_W = MAN_W + 2;           // leading one + mantissa + one truncated bit
  localparam int RAD_W  = 2 * ROOT_W;

  localparam logic [WORD_W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  typedef struct packed {
    logic             sign;
    logic [EXP_W-1:0] exp;
    logic [MAN_W-1:0] man;
  } fp_t;
endpackage

// File: rtl/fp16_sqrt_prep.sv
module fp16_sqrt_prep
  import fp16_sqrt_pkg::*;
(
  input  fp_t              op_i,
  output logic             zero_o,
  output logic             bad_o,
  output logic [EXP_W-1:0] exp_o,
  output logic [RAD_W-1:0] rad_o
);
  localparam logic [EXP_W-1:0] BIAS_V = EXP_W'(BIAS);

  logic             ge_one, odd;
  logic [EXP_W-1:0] sub_a, sub_b, mag, half;
  logic [RAD_W-1:0] rad_full;

  always_comb begin
    ge_one = op_i.exp >= BIAS_V;
    // operand order mux: always subtract the smaller one
    sub_a  = ge_one ? op_i.exp : BIAS_V;
    sub_b  = ge_one ? BIAS_V : op_i.exp;
    mag    = sub_a - sub_b;
    half   = mag >> 1;
    odd    = mag[0];
    // floor of the halved unbiased exponent, re-biased
    exp_o  = ge_one ? BIAS_V + half : BIAS_V - half - EXP_W'(odd);
  end

  // controlled right shift: odd exponent keeps the extra factor of two
  assign rad_full = {1'b1, op_i.man, {(RAD_W-MAN_W-1){1'b0}}};
  assign rad_o    = odd ? rad_full : rad_full >> 1;

  assign zero_o = (op_i == '0);
  assign bad_o  = op_i.sign | (&op_i.exp) | ((op_i.exp == '0) & (op_i.man != '0));
endmodule

// File: rtl/fp16_sqrt_core.sv
module fp16_sqrt_core #(
  parameter  int ROOT_W = 12,
  localparam int RAD_W  = 2 * ROOT_W,
  localparam int REM_W  = ROOT_W + 2,
  localparam int CNT_W  = $clog2(ROOT_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [RAD_W-1:0]  rad_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ROOT_W-3:0] frac_o
);
  logic [RAD_W-1:0]  rad_q;
  logic [REM_W-1:0]  rem_q, rem_nx;
  logic [ROOT_W-1:0] root_q, root_nx;
  logic [CNT_W-1:0]  cnt_q;
  logic [REM_W+1:0]  rem_sh, trial;
  logic              fits;

  always_comb begin
    rem_sh  = {rem_q, rad_q[RAD_W-1 -: 2]};
    trial   = {2'b00, root_q, 2'b01};
    fits    = rem_sh >= trial;
    rem_nx  = fits ? REM_W'(rem_sh - trial) : REM_W'(rem_sh);
    root_nx = {root_q[ROOT_W-2:0], fits};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rad_q  <= '0;
      rem_q  <= '0;
      root_q <= '0;
      cnt_q  <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !busy_o) begin
        rad_q  <= rad_i;
        rem_q  <= '0;
        root_q <= '0;
        cnt_q  <= '0;
        busy_o <= 1'b1;
      end else if (busy_o) begin
        rad_q  <= rad_q << 2;
        rem_q  <= rem_nx;
        root_q <= root_nx;
        cnt_q  <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(ROOT_W - 1)) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  // drop the leading one (always set) and the extra truncation bit
  assign frac_o = root_q[ROOT_W-2:1];
endmodule

// File: rtl/fp16_sqrt.sv
module fp16_sqrt
  import fp16_sqrt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] op_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              invalid_o,
  output logic [WORD_W-1:0] result_o
);
  logic             zero, bad, accept, core_go;
  logic             core_busy, core_done;
  logic [EXP_W-1:0] prep_exp, exp_q;
  logic [RAD_W-1:0] prep_rad;
  logic [MAN_W-1:0] core_man;

  fp16_sqrt_prep u_prep (
    .op_i   (fp_t'(op_i)),
    .zero_o (zero),
    .bad_o  (bad),
    .exp_o  (prep_exp),
    .rad_o  (prep_rad)
  );

  assign busy_o  = core_busy | core_done;
  assign accept  = start_i & ~busy_o;
  assign core_go = accept & ~zero & ~bad;

  fp16_sqrt_core #(.ROOT_W(ROOT_W)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (core_go),
    .rad_i   (prep_rad),
    .busy_o  (core_busy),
    .done_o  (core_done),
    .frac_o  (core_man)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_q     <= '0;
      done_o    <= 1'b0;
      invalid_o <= 1'b0;
      result_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (core_go) exp_q <= prep_exp;
      if (core_done) begin
        result_o  <= {1'b0, exp_q, core_man};
        invalid_o <= 1'b0;
        done_o    <= 1'b1;
      end else if (accept && (zero || bad)) begin
        result_o  <= bad ? QNAN : '0;
        invalid_o <= bad;
        done_o    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fp16_sqrt_chk.sv
module fp16_sqrt_chk
  import fp16_sqrt_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [WORD_W-1:0] op_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              invalid_o,
  input logic [WORD_W-1:0] result_o
);
  logic op_bad, op_zero;
  assign op_zero = (op_i == '0);
  assign op_bad  = op_i[WORD_W-1] | (&op_i[WORD_W-2 -: EXP_W]) |
                   ((op_i[WORD_W-2 -: EXP_W] == '0) & (op_i[MAN_W-1:0] != '0));

  // R1
  bad_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && op_bad |=> done_o && invalid_o && result_o == QNAN);

  // R2
  zero_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && op_zero |=> done_o && !invalid_o && result_o == '0);

  // R5
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && !op_bad && !op_zero |=> busy_o && !done_o);

  // R5
  busy_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o);

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> !done_o);

  // R7
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o) && $stable(invalid_o));

  // R10
  valid_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !invalid_o |-> !result_o[WORD_W-1]);

  // R10
  valid_exp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !invalid_o && result_o != '0 |->
      result_o[WORD_W-2 -: EXP_W] >= EXP_W'(8) && result_o[WORD_W-2 -: EXP_W] <= EXP_W'(22));
endmodule

bind fp16_sqrt fp16_sqrt_chk u_chk (.*);

// File: tb/tb_fp16_sqrt.sv
module tb_fp16_sqrt;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] op_i = '0;
  logic        busy_o, done_o, invalid_o;
  logic [15:0] result_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  fp16_sqrt dut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one operand, wait for done; lat counts rising edges incl. the accepting one
  task automatic run_op(input logic [15:0] op, output logic [15:0] res,
                        output logic inv, output int lat);
    @(negedge clk_i);
    start_i = 1'b1;
    op_i    = op;
    lat     = 0;
    do begin
      @(negedge clk_i);
      start_i = 1'b0;
      lat++;
    end while (!done_o && lat < 40);
    res = result_o;
    inv = invalid_o;
  endtask

  task automatic check_root(input logic [15:0] op, input logic [15:0] res);
    int     e, u, eo, k;
    longint s, q, lhs;
    e  = int'(op[14:10]);
    u  = e - 15;
    eo = 15 + (u >>> 1);
    k  = u & 1;
    s  = 1024 + longint'(op[9:0]);
    q  = 1024 + longint'(res[9:0]);
    lhs = s << (10 + k);
    check($sformatf("R3 exponent of %h", op), 32'(res[14:10]), 32'(eo));
    check($sformatf("R4 lower bound of %h", op), 32'(q * q <= lhs), 32'd1);
    check($sformatf("R4 upper bound of %h", op), 32'(lhs < (q + 1) * (q + 1)), 32'd1);
    check($sformatf("R10 sign of %h", op), 32'(res[15]), 32'd0);
  endtask

  task automatic t_reset();
    check("R7 reset done", 32'(done_o), 32'd0);
    check("R5 reset busy", 32'(busy_o), 32'd0);
    check("R7 reset result", 32'(result_o), 32'd0);
    check("R1 reset invalid", 32'(invalid_o), 32'd0);
  endtask

  task automatic t_special();
    logic [15:0] res; logic inv; int lat;
    logic [15:0] bads [5] = '{16'hBC00, 16'h8000, 16'h7C00, 16'h7E01, 16'h0001};
    foreach (bads[i]) begin
      run_op(bads[i], res, inv, lat);
      check($sformatf("R1 nan for %h", bads[i]), 32'(res), 32'h7E00);
      check($sformatf("R1 flag for %h", bads[i]), 32'(inv), 32'd1);
      check($sformatf("R1 latency for %h", bads[i]), 32'(lat), 32'd1);
    end
    run_op(16'h0000, res, inv, lat);
    check("R2 zero result", 32'(res), 32'h0);
    check("R2 zero flag", 32'(inv), 32'd0);
    check("R2 zero latency", 32'(lat), 32'd1);
  endtask

  task automatic t_exact();
    logic [15:0] res; logic inv; int lat;
    run_op(16'h4400, res, inv, lat);
    check("R8 sqrt 4.0", 32'(res), 32'h4000);
    check("R5 latency", 32'(lat), 32'd14);
    check("R10 valid flag", 32'(inv), 32'd0);
    run_op(16'h3400, res, inv, lat);
    check("R8 sqrt 0.25", 32'(res), 32'h3800);
    run_op(16'h3C00, res, inv, lat);
    check("R8 sqrt 1.0", 32'(res), 32'h3C00);
    run_op(16'h4000, res, inv, lat);
    check("R9 sqrt 2.0", 32'(res), 32'h3DA8);
    run_op(16'h3800, res, inv, lat);
    check("R9 sqrt 0.5", 32'(res), 32'h39A8);
  endtask

  task automatic t_sweep();
    logic [15:0] res; logic inv; int lat;
    logic [15:0] ops [10] = '{16'h0400, 16'h7BFF, 16'h4A00, 16'h4E3F, 16'h2D55,
                              16'h3555, 16'h3FFF, 16'h3BFF, 16'h5A5A, 16'h1234};
    foreach (ops[i]) begin
      run_op(ops[i], res, inv, lat);
      check_root(ops[i], res);
      check($sformatf("R5 latency of %h", ops[i]), 32'(lat), 32'd14);
    end
  endtask

  task automatic t_ignore();
    int lat;
    bit extra;
    @(negedge clk_i);
    start_i = 1'b1;
    op_i    = 16'h4400;
    lat     = 0;
    do begin
      @(negedge clk_i);
      lat++;
      if (lat == 3) check("R5 busy during root", 32'(busy_o), 32'd1);
      // zero operand while busy would complete at once if taken
      start_i = (lat == 3 || lat == 7);
      op_i    = (lat == 1) ? 16'h4400 : 16'h0000;
    end while (!done_o && lat < 40);
    start_i = 1'b0;
    check("R6 latency with ignored start", 32'(lat), 32'd14);
    check("R6 result of accepted op", 32'(result_o), 32'h4000);
    extra = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      if (done_o) extra = 1'b1;
    end
    check("R6 no extra completion", 32'(extra), 32'd0);
    check("R7 result held", 32'(result_o), 32'h4000);
    check("R7 done pulse ended", 32'(done_o), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_special();
    t_exact();
    t_sweep();
    t_ignore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule